// File: doc/BRIEF.md
# CCD Line Pixel Role Tagger

This block sits next to the timing generator of a linear colour image sensor and labels each element period of a readout line with the role that element plays. Each line holds, in a fixed order, leading dummy elements, optically shielded (dark) elements, a short dummy gap, the effective signal elements and a trailing group that contains one test element. The lengths of these segments depend on the readout mode. In colour mode one output carries the whole line. In monochrome (B/W) mode the effective pixels are split between two outputs, one carrying the odd-numbered pixels and the other the even-numbered ones. The block reports the pixel number carried by each output.

A `line_start` pulse opens a line and samples the mode select. Each `pix_stb` pulse advances one element. From the element's position the block registers a role code, the effective pixel number or numbers, and a flag that marks signal elements. While the shielded elements pass, the sample word is summed. On the last shielded element the sum is divided by the segment length, and the result is held as the line's black level. If a new line starts before the current one has reached its full length, the block restarts classification and sets a sticky error flag.

Top module: `pix_role_tagger`

## Requirements
- R1: After reset, `cls` is 0, `sig_valid` is 0, both index outputs are 0, `blk_level` is 0 and `short_err` is 0.
- R2: In colour mode (`bw_sel`=0 at line start), positions 0..5489 of a line are coded in order as follows: 26 dummy (code 0), 96 shielded (code 1), 6 dummy (code 0), 5340 signal (code 2) and 22 trailing elements. The trailing elements are code 4, except the 13th one (position 5480), which is test (code 3).
- R3: In B/W mode (`bw_sel`=1 at line start), positions 0..2744 are coded in order as follows: 13 dummy (0), 48 shielded (1), 3 dummy (0), 2670 signal (2) and 11 trailing elements. The trailing elements are code 4, except the 7th one (position 2740), which is test (3).
- R4: `sig_valid` is 1 exactly while the latest element is a signal element. In colour mode `eff_idx` counts 1..5340 over the signal elements and `eff_idx_even` stays 0. A line start clears both indices.
- R5: In B/W mode, for the k-th signal element (k=1..2670), `eff_idx` is 2k-1 (the odd-pixel output) and `eff_idx_even` is 2k (the even-pixel output).
- R6: Outputs change on the clock edge that samples `pix_stb`, so they are visible one cycle after the strobe. They hold between strobes.
- R7: The mode is sampled only at `line_start`. Changing `bw_sel` in the middle of a line has no effect on that line.
- R8: On the last shielded element, `blk_level` becomes floor(sum of the shielded `pix_data` words / shielded count), with a count of 96 in colour mode and 48 in B/W mode. It then holds until the next update.
- R9: A `line_start` that arrives after a line has begun but before it has reached its full length sets `short_err`. The flag stays set until reset. Classification restarts from position 0.
- R10: Strobes that arrive after the last element of a line give code 4 with `sig_valid` 0, and the indices hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Opens a line and samples `bw_sel` |
| pix_stb | input | 1 | One element period has elapsed |
| bw_sel | input | 1 | 1 selects B/W mode, 0 selects colour mode |
| pix_data | input | DW | Sample word for the current element |
| cls | output | 3 | Role code of the latest element |
| eff_idx | output | IW | Colour pixel number, or odd pixel number in B/W mode |
| eff_idx_even | output | IW | Even pixel number in B/W mode, 0 in colour mode |
| sig_valid | output | 1 | The latest element is a signal element |
| blk_level | output | DW | Black level averaged from the shielded samples |
| short_err | output | 1 | Sticky flag for a line that started early |

## Verification
A full colour line is strobed on every cycle. Every element's code and index are compared, which separates the off-by-one boundary cases of each segment and the position of the test element. A B/W line is then strobed on every other cycle while `bw_sel` is flipped mid-line. This distinguishes the halved map and the odd/even pairing from the colour map, and shows that holding between strobes and mode latching work. Over-long strobing, a truncated line followed by a full line, and shielded data that does not divide evenly cover saturation, the sticky error with restart, and the truncating average.

// File: rtl/pix_role_tagger.sv
module pix_role_tagger #(
  parameter int DW       = 12,
  parameter int CLR_LEAD = 26,
  parameter int CLR_SHLD = 96,
  parameter int CLR_GAP  = 6,
  parameter int CLR_SIG  = 5340,
  parameter int CLR_TAIL = 22,
  parameter int CLR_TEST = 12,
  parameter int BW_LEAD  = 13,
  parameter int BW_SHLD  = 48,
  parameter int BW_GAP   = 3,
  parameter int BW_SIG   = 2670,
  parameter int BW_TAIL  = 11,
  parameter int BW_TEST  = 6,
  parameter int IW       = $clog2(CLR_SIG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          pix_stb,
  input  logic          bw_sel,
  input  logic [DW-1:0] pix_data,
  output logic [2:0]    cls,
  output logic [IW-1:0] eff_idx,
  output logic [IW-1:0] eff_idx_even,
  output logic          sig_valid,
  output logic [DW-1:0] blk_level,
  output logic          short_err
);
  localparam int CLR_LEN = CLR_LEAD + CLR_SHLD + CLR_GAP + CLR_SIG + CLR_TAIL;
  localparam int PW = $clog2(CLR_LEN + 1);
  localparam int AW = DW + $clog2(CLR_SHLD + 1);

  localparam logic [2:0] K_DUMMY = 3'd0;
  localparam logic [2:0] K_DARK  = 3'd1;
  localparam logic [2:0] K_SIG   = 3'd2;
  localparam logic [2:0] K_TEST  = 3'd3;
  localparam logic [2:0] K_TAIL  = 3'd4;

  logic          bw_q, in_line;
  logic [PW-1:0] pos;
  logic [AW-1:0] acc;

  logic [PW-1:0] sh_beg, sh_end, sig_beg, sig_end, tst_pos, len;
  assign sh_beg  = bw_q ? PW'(BW_LEAD) : PW'(CLR_LEAD);
  assign sh_end  = sh_beg + (bw_q ? PW'(BW_SHLD) : PW'(CLR_SHLD));
  assign sig_beg = sh_end + (bw_q ? PW'(BW_GAP) : PW'(CLR_GAP));
  assign sig_end = sig_beg + (bw_q ? PW'(BW_SIG) : PW'(CLR_SIG));
  assign tst_pos = sig_end + (bw_q ? PW'(BW_TEST) : PW'(CLR_TEST));
  assign len     = sig_end + (bw_q ? PW'(BW_TAIL) : PW'(CLR_TAIL));

  logic [2:0] cls_n;
  always_comb begin
    if (pos < sh_beg)        cls_n = K_DUMMY;
    else if (pos < sh_end)   cls_n = K_DARK;
    else if (pos < sig_beg)  cls_n = K_DUMMY;
    else if (pos < sig_end)  cls_n = K_SIG;
    else if (pos == tst_pos) cls_n = K_TEST;
    else                     cls_n = K_TAIL;
  end

  wire           adv    = pix_stb && !line_start && in_line;
  wire [PW-1:0]  k      = pos - sig_beg + PW'(1);
  wire [PW:0]    k2     = {k, 1'b0};
  wire [AW-1:0]  acc_n  = acc + AW'(pix_data);
  wire [AW-1:0]  avg    = bw_q ? acc_n / AW'(BW_SHLD) : acc_n / AW'(CLR_SHLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bw_q <= 1'b0; in_line <= 1'b0; pos <= '0; acc <= '0;
      cls <= K_DUMMY; eff_idx <= '0; eff_idx_even <= '0;
      sig_valid <= 1'b0; blk_level <= '0; short_err <= 1'b0;
    end else if (line_start) begin
      if (in_line && pos < len) short_err <= 1'b1;
      in_line <= 1'b1; bw_q <= bw_sel; pos <= '0; acc <= '0;
      cls <= K_DUMMY; sig_valid <= 1'b0; eff_idx <= '0; eff_idx_even <= '0;
    end else if (adv) begin
      cls       <= cls_n;
      sig_valid <= (cls_n == K_SIG);
      if (pos < len) pos <= pos + PW'(1);
      if (cls_n == K_SIG) begin
        if (bw_q) begin
          eff_idx      <= IW'(k2 - (PW+1)'(1));
          eff_idx_even <= IW'(k2);
        end else begin
          eff_idx      <= IW'(k);
          eff_idx_even <= '0;
        end
      end
      if (cls_n == K_DARK) begin
        acc <= acc_n;
        if (pos == sh_end - PW'(1)) blk_level <= DW'(avg);
      end
    end
  end
endmodule

module role_tagger_chk #(
  parameter int DW = 12,
  parameter int IW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic          pix_stb,
  input logic [2:0]    cls,
  input logic [IW-1:0] eff_idx,
  input logic [IW-1:0] eff_idx_even,
  input logic          sig_valid,
  input logic [DW-1:0] blk_level,
  input logic          short_err
);
  AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cls <= 3'd4); // R2
  AST_VALID_IS_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n) sig_valid == (cls == 3'd2)); // R4
  AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rst_n) $rose(sig_valid) |-> (eff_idx == IW'(1) || eff_idx_even == IW'(2))); // R4
  AST_EVEN_PAIRS_ODD: assert property (@(posedge clk) disable iff (!rst_n) (eff_idx_even != '0) |-> (eff_idx_even == eff_idx + IW'(1))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!pix_stb && !line_start) |=> ($stable(cls) && $stable(eff_idx) && $stable(sig_valid))); // R6
  AST_BLACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pix_stb |=> $stable(blk_level)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) short_err |=> short_err); // R9
endmodule

bind pix_role_tagger role_tagger_chk #(.DW(DW), .IW(IW)) u_chk (.*);

// File: tb/sim_pix_role_tagger.sv
module sim_pix_role_tagger;
  localparam int DW = 12;
  localparam int IW = 13;

  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, pix_stb = 1'b0, bw_sel = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic [2:0] cls;
  logic [IW-1:0] eff_idx, eff_idx_even;
  logic sig_valid, short_err;
  logic [DW-1:0] blk_level;

  int checks = 0, failures = 0;
  int exp_blk = 0;
  int last_idx = 0;

  always #4 clk = ~clk;

  pix_role_tagger u0 (.clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_stb(pix_stb),
    .bw_sel(bw_sel), .pix_data(pix_data), .cls(cls), .eff_idx(eff_idx),
    .eff_idx_even(eff_idx_even), .sig_valid(sig_valid), .blk_level(blk_level),
    .short_err(short_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_class(input bit bw, input int p);
    if (!bw) begin
      if (p < 26) return 0;
      if (p < 122) return 1;
      if (p < 128) return 0;
      if (p < 5468) return 2;
      if (p == 5480) return 3;
      return 4;
    end
    if (p < 13) return 0;
    if (p < 61) return 1;
    if (p < 64) return 0;
    if (p < 2734) return 2;
    if (p == 2740) return 3;
    return 4;
  endfunction

  function automatic int dat(input int p);
    return (p * 37 + 5) % 4096;
  endfunction

  task automatic start_line(input bit bw);
    @(negedge clk);
    bw_sel = bw; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    last_idx = 0;
  endtask

  task automatic run_elems(input bit bw, input int n, input int gap, input bit flip);
    int sh_lo, sh_hi, sig_lo, sum;
    sh_lo = bw ? 13 : 26;
    sh_hi = bw ? 60 : 121;
    sig_lo = bw ? 64 : 128;
    sum = 0;
    for (int p = 0; p < n; p++) begin
      int ec, k, ei, ee;
      if (flip && p == 10) bw_sel = ~bw_sel; // R7 mid-line change
      pix_stb = 1'b1; pix_data = DW'(dat(p));
      @(negedge clk);
      pix_stb = 1'b0;
      ec = exp_class(bw, p);
      if (ec == 1) sum += dat(p);
      if (p == sh_hi) exp_blk = sum / (bw ? 48 : 96);
      if (ec == 2) begin
        k = p - sig_lo + 1;
        ei = bw ? 2 * k - 1 : k;
        ee = bw ? 2 * k : 0;
        last_idx = ei;
      end else begin
        ei = last_idx;
        ee = (bw && last_idx != 0) ? last_idx + 1 : 0;
      end
      chk(int'(cls) == ec, bw ? "R3 class" : "R2 class", cls, ec);
      chk(sig_valid == (ec == 2), "R4 valid", sig_valid, ec == 2);
      chk(int'(eff_idx) == ei, bw ? "R5 odd index" : "R4 index", eff_idx, ei);
      chk(int'(eff_idx_even) == ee, bw ? "R5 even index" : "R4 even index zero", eff_idx_even, ee);
      if (p >= sh_lo && p <= sh_hi + 1)
        chk(int'(blk_level) == exp_blk, "R8 black level", blk_level, exp_blk);
      for (int g = 0; g < gap; g++) @(negedge clk);
      if (gap > 0 && p == sig_lo)
        chk(int'(cls) == 2 && int'(eff_idx) == ei, "R6 hold between strobes", cls, 2);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cls == 3'd0 && sig_valid == 1'b0, "R1 class/valid", cls, 0);
    chk(eff_idx == '0 && eff_idx_even == '0, "R1 indices", eff_idx, 0);
    chk(blk_level == '0 && short_err == 1'b0, "R1 black/err", blk_level, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_color_line;
    start_line(1'b0);
    chk(eff_idx == '0, "R4 index cleared at line start", eff_idx, 0);
    run_elems(1'b0, 5490, 0, 1'b0);
    chk(short_err == 1'b0, "R9 no error on full line", short_err, 0);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 3; i++) begin
      pix_stb = 1'b1;
      @(negedge clk);
      pix_stb = 1'b0;
      chk(cls == 3'd4 && sig_valid == 1'b0, "R10 past-end class", cls, 4);
      chk(int'(eff_idx) == 5340, "R10 index holds", eff_idx, 5340);
    end
  endtask

  task automatic t_bw_line;
    start_line(1'b1);
    run_elems(1'b1, 2745, 1, 1'b1);
    chk(short_err == 1'b0, "R9 no error after B/W line", short_err, 0);
  endtask

  task automatic t_short_line;
    start_line(1'b1);
    run_elems(1'b1, 50, 0, 1'b0);
    chk(short_err == 1'b0, "R9 no error before restart", short_err, 0);
    start_line(1'b0);
    chk(short_err == 1'b1, "R9 error raised on early start", short_err, 1);
    chk(cls == 3'd0 && eff_idx == '0, "R9 restart clears", cls, 0);
    run_elems(1'b0, 5490, 0, 1'b0);
    chk(short_err == 1'b1, "R9 error sticky", short_err, 1);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_color_line();
    t_overrun();
    t_bw_line();
    t_short_line();
    finish_run();
  end
endmodule